// File: doc/BRIEF.md
# Serial flash and RAM memory bridge

This block sits between a 16-bit, word-addressed processor and two external serial memories that share one serial clock and a set of IO pins. A quad-capable flash serves instruction fetch and constant loads and is only ever read. A plain single-bit SPI RAM serves data loads and stores. Every transfer moves exactly one aligned 16-bit word. The byte address on the wire is the word address shifted left by one.

Out of reset the bridge first puts the flash through a fixed setup: it resets the device, sets the quad-enable bit and enters continuous read. Only then does it accept processor requests. After that, a flash read skips the command byte and starts directly with the quad address. The processor raises `req` with the target, direction, address and write data, and holds them until `ready` pulses. A request to write the flash is accepted and completed without touching any pin.

Top module: `sermem_bridge`

## Requirements
- R1: After reset the flash receives five framed commands in this order, and `init_done` stays low until the fifth frame has ended. The frames are 0x66, then 0x99, then 0x06, then 0x31 followed by 0x02, then 0xEB followed by six quad address nibbles of zero, the mode byte 0xA0 and four dummy clocks (20 clocks). `ready` never pulses before `init_done` is high, and a request raised during setup waits.
- R2: `ram_cs_n` stays high for the whole setup, and the two chip selects are never low together.
- R3: The 24-bit byte address sent to either memory is {7'b0, word_address[15:0], 1'b0}, sent most significant bit first.
- R4: A flash read is one frame of 16 clocks. It has 6 quad address clocks and two mode nibbles 0xA and 0x0, with IO driven. Then come 4 dummy clocks and 4 data clocks with `io_oe` = 0000. The first data nibble received is bits 15:12 of `rdata`.
- R5: `sclk` is high for exactly one system clock at a time, with at least one low cycle between highs. It is high only while a chip select is low, and it stays low outside transfers.
- R6: A RAM read is one frame of 48 clocks: command 0x03 on IO0, then the 24-bit address on IO0, then 16 data bits taken from IO1, MSB first.
- R7: A RAM write is one frame of 48 clocks on IO0: command 0x02, then the 24-bit address, then the 16 data bits, MSB first.
- R8: A flash write request causes no chip select activity, and `ready` pulses in the cycle after it is accepted.
- R9: `ready` is a single-cycle pulse, and `rdata` is valid with it. Request fields are captured at acceptance, so changes while a transfer runs have no effect.
- R10: During every single-bit phase, `io_oe` = 1101 (IO0 out, IO1 in, IO2 and IO3 out), and IO2 and IO3 are driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request held until `ready` |
| req_flash | input | 1 | 1 selects flash, 0 selects RAM |
| req_we | input | 1 | 1 for write, 0 for read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with `ready` |
| init_done | output | 1 | Flash setup finished |
| flash_cs_n | output | 1 | Flash chip select, active low |
| ram_cs_n | output | 1 | RAM chip select, active low |
| sclk | output | 1 | Shared serial clock |
| io_in | input | 4 | IO pad inputs (IO1 is MISO in single mode) |
| io_out | output | 4 | IO pad output values |
| io_oe | output | 4 | Per-pad output enables |

## Verification
A wrong phase step or job code shows up first as a clock count or a byte that differs on the wire, and within the very frame concerned. The bench therefore decodes every frame at the pins, as a device would. A stuck or skipped setup frame shows up as a missing or misordered command before `init_done`. A bad shift or capture path shows as corrupted `rdata` or stored RAM words on the next read-back. Clock-shape or chip-select errors are caught by the cycle-level monitors in the cycle they happen.

// File: rtl/sermem_pkg.sv
package sermem_pkg;
  localparam int WORD_W  = 16;
  localparam int BADDR_W = 24;
  localparam int SH_W    = 32;
  localparam int CNT_W   = 6;
  localparam int NIB_W   = 4;

  localparam logic [7:0] CMD_RST_EN   = 8'h66;
  localparam logic [7:0] CMD_RST      = 8'h99;
  localparam logic [7:0] CMD_WREN     = 8'h06;
  localparam logic [7:0] CMD_WRSR2    = 8'h31;
  localparam logic [7:0] SR2_QUAD     = 8'h02;
  localparam logic [7:0] CMD_QREAD    = 8'hEB;
  localparam logic [7:0] MODE_CONT    = 8'hA0;
  localparam logic [7:0] CMD_RAM_RD   = 8'h03;
  localparam logic [7:0] CMD_RAM_WR   = 8'h02;

  localparam logic [3:0] OE_SINGLE  = 4'b1101;
  localparam logic [3:0] OE_QOUT    = 4'b1111;
  localparam logic [3:0] OE_RELEASE = 4'b0000;

  typedef enum logic [3:0] {
    J_INIT0, J_INIT1, J_INIT2, J_INIT3, J_INIT4,
    J_FREAD, J_RREAD, J_RWRITE, J_BLOCK
  } job_e;

  typedef struct packed {
    logic             quad;
    logic [3:0]       oe;
    logic [CNT_W-1:0] nclk;
    logic [SH_W-1:0]  tx;
    logic             cap;
    logic             last;
  } phase_t;

  // word address to wire byte address
  function automatic logic [BADDR_W-1:0] byte_addr(input logic [WORD_W-1:0] w);
    return {{(BADDR_W-WORD_W-1){1'b0}}, w, 1'b0};
  endfunction

  function automatic phase_t mk(input logic q, input logic [3:0] oe,
                                input logic [CNT_W-1:0] n, input logic [SH_W-1:0] tx,
                                input logic cap, input logic last);
    phase_t p;
    p.quad = q; p.oe = oe; p.nclk = n; p.tx = tx; p.cap = cap; p.last = last;
    return p;
  endfunction

  // phase descriptor for a given job and step
  function automatic phase_t phase_of(input job_e job, input logic [1:0] idx,
                                      input logic [WORD_W-1:0] waddr,
                                      input logic [WORD_W-1:0] wdata);
    logic [BADDR_W-1:0] ba;
    phase_t p;
    ba = byte_addr(waddr);
    p  = mk(1'b0, OE_SINGLE, 6'd8, '0, 1'b0, 1'b1);
    case (job)
      J_INIT0: p = mk(1'b0, OE_SINGLE, 6'd8,  {CMD_RST_EN, 24'h0}, 1'b0, 1'b1);
      J_INIT1: p = mk(1'b0, OE_SINGLE, 6'd8,  {CMD_RST, 24'h0}, 1'b0, 1'b1);
      J_INIT2: p = mk(1'b0, OE_SINGLE, 6'd8,  {CMD_WREN, 24'h0}, 1'b0, 1'b1);
      J_INIT3: p = mk(1'b0, OE_SINGLE, 6'd16, {CMD_WRSR2, SR2_QUAD, 16'h0}, 1'b0, 1'b1);
      J_INIT4: begin
        case (idx)
          2'd0:    p = mk(1'b0, OE_SINGLE, 6'd8, {CMD_QREAD, 24'h0}, 1'b0, 1'b0);
          2'd1:    p = mk(1'b1, OE_QOUT, 6'd6, '0, 1'b0, 1'b0);
          2'd2:    p = mk(1'b1, OE_QOUT, 6'd2, {MODE_CONT, 24'h0}, 1'b0, 1'b0);
          default: p = mk(1'b1, OE_RELEASE, 6'd4, '0, 1'b0, 1'b1);
        endcase
      end
      J_FREAD: begin
        case (idx)
          2'd0:    p = mk(1'b1, OE_QOUT, 6'd6, {ba, 8'h0}, 1'b0, 1'b0);
          2'd1:    p = mk(1'b1, OE_QOUT, 6'd2, {MODE_CONT, 24'h0}, 1'b0, 1'b0);
          2'd2:    p = mk(1'b1, OE_RELEASE, 6'd4, '0, 1'b0, 1'b0);
          default: p = mk(1'b1, OE_RELEASE, 6'd4, '0, 1'b1, 1'b1);
        endcase
      end
      J_RREAD: begin
        case (idx)
          2'd0:    p = mk(1'b0, OE_SINGLE, 6'd8, {CMD_RAM_RD, 24'h0}, 1'b0, 1'b0);
          2'd1:    p = mk(1'b0, OE_SINGLE, 6'd24, {ba, 8'h0}, 1'b0, 1'b0);
          default: p = mk(1'b0, OE_SINGLE, 6'd16, '0, 1'b1, 1'b1);
        endcase
      end
      J_RWRITE: begin
        case (idx)
          2'd0:    p = mk(1'b0, OE_SINGLE, 6'd8, {CMD_RAM_WR, 24'h0}, 1'b0, 1'b0);
          2'd1:    p = mk(1'b0, OE_SINGLE, 6'd24, {ba, 8'h0}, 1'b0, 1'b0);
          default: p = mk(1'b0, OE_SINGLE, 6'd16, {wdata, 16'h0}, 1'b0, 1'b1);
        endcase
      end
      default: p = mk(1'b0, OE_SINGLE, 6'd8, '0, 1'b0, 1'b1);
    endcase
    return p;
  endfunction
endpackage

// File: rtl/sermem_phase.sv
module sermem_phase
  import sermem_pkg::*;
(
  input  job_e              job_i,
  input  logic [1:0]        idx_i,
  input  logic [WORD_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output phase_t            phase_o
);
  always_comb phase_o = phase_of(job_i, idx_i, waddr_i, wdata_i);
endmodule

// File: rtl/sermem_shift.sv
module sermem_shift #(
  parameter int SH_W  = 32,
  parameter int CNT_W = 6,
  parameter int RX_W  = 16,
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             quad_i,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] nclk_i,
  input  logic [SH_W-1:0]  tx_i,
  input  logic [NIB_W-1:0] io_in_i,
  output logic             sclk_o,
  output logic [NIB_W-1:0] nib_o,
  output logic [RX_W-1:0]  rx_o,
  output logic             done_o
);
  logic             active, sclk_q, quad_q, cap_q, done_q;
  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0]  sh;
  logic [RX_W-1:0]  rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; sclk_q <= 1'b0; quad_q <= 1'b0; cap_q <= 1'b0;
      done_q <= 1'b0; cnt <= '0; sh <= '0; rx <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        active <= 1'b1; sclk_q <= 1'b0; sh <= tx_i; cnt <= nclk_i;
        quad_q <= quad_i; cap_q <= cap_i;
      end else if (active) begin
        if (!sclk_q) begin
          // rising serial edge: sample the pads
          sclk_q <= 1'b1;
          if (cap_q)
            rx <= quad_q ? {rx[RX_W-NIB_W-1:0], io_in_i} : {rx[RX_W-2:0], io_in_i[1]};
        end else begin
          // falling serial edge: present next bits
          sclk_q <= 1'b0;
          sh     <= quad_q ? (sh << NIB_W) : (sh << 1);
          cnt    <= cnt - 1'b1;
          if (cnt == 1) begin
            active <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign nib_o  = sh[SH_W-1 -: NIB_W];
  assign rx_o   = rx;
  assign done_o = done_q;

  p_sclk_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |=> !sclk_q);
  p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!sclk_q && !active));
endmodule

// File: rtl/sermem_pins.sv
module sermem_pins
  import sermem_pkg::*;
(
  input  logic             frame_i,
  input  logic             quad_i,
  input  logic [3:0]       oe_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic [3:0]       io_out_o,
  output logic [3:0]       io_oe_o
);
  always_comb begin
    if (!frame_i) begin
      io_out_o = 4'b1100;
      io_oe_o  = OE_SINGLE;
    end else if (quad_i) begin
      io_out_o = nib_i;
      io_oe_o  = oe_i;
    end else begin
      io_out_o = {2'b11, 1'b0, nib_i[NIB_W-1]};
      io_oe_o  = oe_i;
    end
  end
endmodule

// File: rtl/sermem_bridge.sv
module sermem_bridge
  import sermem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_flash,
  input  logic              req_we,
  input  logic [WORD_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              ready,
  output logic [WORD_W-1:0] rdata,
  output logic              init_done,
  output logic              flash_cs_n,
  output logic              ram_cs_n,
  output logic              sclk,
  input  logic [3:0]        io_in,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe
);
  typedef enum logic [2:0] {S_START, S_IDLE, S_LAUNCH, S_WAIT, S_END} st_e;

  st_e               st;
  job_e              job;
  logic [1:0]        idx;
  logic [WORD_W-1:0] addr_q, wdata_q;
  logic              init_q;
  phase_t            ph;

  logic              eng_done, eng_sclk;
  logic [NIB_W-1:0]  eng_nib;
  logic [WORD_W-1:0] eng_rx;

  // named internal events
  wire frame     = (st == S_LAUNCH) || (st == S_WAIT);
  wire launch    = (st == S_LAUNCH);
  wire accept    = (st == S_IDLE) && req && init_q;
  wire blocked   = req_flash && req_we;
  wire flash_job = (job <= J_INIT4) || (job == J_FREAD);
  wire ram_job   = (job == J_RREAD) || (job == J_RWRITE);

  sermem_phase u_phase (
    .job_i(job), .idx_i(idx), .waddr_i(addr_q), .wdata_i(wdata_q), .phase_o(ph)
  );

  sermem_shift #(.SH_W(SH_W), .CNT_W(CNT_W), .RX_W(WORD_W), .NIB_W(NIB_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start_i(launch), .quad_i(ph.quad), .cap_i(ph.cap),
    .nclk_i(ph.nclk), .tx_i(ph.tx), .io_in_i(io_in), .sclk_o(eng_sclk),
    .nib_o(eng_nib), .rx_o(eng_rx), .done_o(eng_done)
  );

  sermem_pins u_pins (
    .frame_i(frame), .quad_i(ph.quad), .oe_i(ph.oe), .nib_i(eng_nib),
    .io_out_o(io_out), .io_oe_o(io_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_START; job <= J_INIT0; idx <= '0;
      addr_q <= '0; wdata_q <= '0; init_q <= 1'b0;
    end else begin
      case (st)
        S_START: st <= S_LAUNCH;
        S_IDLE: begin
          if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            idx     <= '0;
            if (blocked) begin
              job <= J_BLOCK;
              st  <= S_END;
            end else begin
              job <= req_flash ? J_FREAD : (req_we ? J_RWRITE : J_RREAD);
              st  <= S_LAUNCH;
            end
          end
        end
        S_LAUNCH: st <= S_WAIT;
        S_WAIT: begin
          if (eng_done) begin
            if (ph.last) st <= S_END;
            else begin
              idx <= idx + 1'b1;
              st  <= S_LAUNCH;
            end
          end
        end
        S_END: begin
          idx <= '0;
          if (job == J_INIT4) begin
            init_q <= 1'b1;
            st     <= S_IDLE;
          end else if (job < J_INIT4) begin
            job <= job_e'(job + 4'd1);
            st  <= S_LAUNCH;
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ready      = (st == S_END) && (job >= J_FREAD);
  assign rdata      = eng_rx;
  assign init_done  = init_q;
  assign flash_cs_n = !(frame && flash_job);
  assign ram_cs_n   = !(frame && ram_job);
  assign sclk       = eng_sclk;

  p_fetch_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !init_q |-> !ready);
  p_ram_quiet_boot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !init_q |-> ram_cs_n);
  p_cs_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!flash_cs_n && !ram_cs_n));
  p_sclk_framed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> (!flash_cs_n || !ram_cs_n));
  p_blocked_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && blocked) |=> (ready && flash_cs_n && ram_cs_n));
  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  p_single_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame && !ph.quad) |-> (io_oe[3:2] == 2'b11 && io_out[3:2] == 2'b11));
endmodule

// File: tb/sermem_bridge_test.sv
`timescale 1ns/1ps
module sermem_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, req_flash, req_we;
  logic [15:0] req_addr, req_wdata;
  logic        ready, init_done, flash_cs_n, ram_cs_n, sclk;
  logic [15:0] rdata;
  logic [3:0]  io_in, io_out, io_oe;

  always #2 clk = ~clk;

  sermem_bridge uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_flash(req_flash), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .rdata(rdata),
    .init_done(init_done), .flash_cs_n(flash_cs_n), .ram_cs_n(ram_cs_n),
    .sclk(sclk), .io_in(io_in), .io_out(io_out), .io_oe(io_oe)
  );

  int n_checks = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] flash_word(input logic [15:0] w);
    return {w[7:0] ^ 8'h3C, w[15:8] + 8'h11};
  endfunction

  function automatic logic [23:0] wire_addr(input logic [15:0] w);
    return {7'b0, w, 1'b0};
  endfunction

  // device-side frame recorder
  logic [3:0]  rec_out [64];
  logic [3:0]  rec_oe  [64];
  int          cnt = 0;
  int          flash_frames = 0;
  int          ram_frames = 0;
  int          sclk_long = 0;
  int          sclk_nocs = 0;
  int          cs_both = 0;
  int          ram_during_boot = 0;
  int          cycles = 0;
  logic [15:0] ram_mem [256];
  logic [15:0] exp_ram [256];
  logic        sclk_q, fcs_q, rcs_q;

  function automatic logic [31:0] sbits(input int s, input int n);
    logic [31:0] v = '0;
    for (int i = s; i < s + n; i++) v = {v[30:0], rec_out[i][0]};
    return v;
  endfunction

  function automatic logic [31:0] qnibs(input int s, input int n);
    logic [31:0] v = '0;
    for (int i = s; i < s + n; i++) v = {v[27:0], rec_out[i]};
    return v;
  endfunction

  function automatic bit single_ok(input int s, input int n);
    bit ok = 1'b1;
    for (int i = s; i < s + n; i++)
      if (rec_oe[i] != 4'b1101 || rec_out[i][3:2] != 2'b11) ok = 1'b0;
    return ok;
  endfunction

  function automatic bit released(input int s, input int n);
    bit ok = 1'b1;
    for (int i = s; i < s + n; i++) if (rec_oe[i] != 4'b0000) ok = 1'b0;
    return ok;
  endfunction

  task automatic check_init(input int k);
    logic [31:0] exp_cmd;
    chk(ram_frames == 0, "R2 ram frame during setup", 32'(ram_frames), 32'd0);
    case (k)
      0: exp_cmd = 32'h66;
      1: exp_cmd = 32'h99;
      2: exp_cmd = 32'h06;
      3: exp_cmd = 32'h31;
      default: exp_cmd = 32'hEB;
    endcase
    chk(sbits(0, 8) == exp_cmd, "R1 setup command", sbits(0, 8), exp_cmd);
    chk(single_ok(0, 8), "R10 single phase IO2/IO3", 32'(rec_oe[0]), 32'hD);
    if (k == 3) begin
      chk(cnt == 16, "R1 status write length", 32'(cnt), 32'd16);
      chk(sbits(8, 8) == 32'h02, "R1 quad enable data", sbits(8, 8), 32'h02);
    end else if (k == 4) begin
      chk(cnt == 20, "R1 continuous read entry length", 32'(cnt), 32'd20);
      chk(qnibs(8, 6) == 32'h0, "R1 entry address zero", qnibs(8, 6), 32'h0);
      chk(qnibs(14, 2) == 32'hA0, "R1 entry mode byte", qnibs(14, 2), 32'hA0);
      chk(released(16, 4), "R4 entry dummy released", 32'(rec_oe[16]), 32'h0);
    end else begin
      chk(cnt == 8, "R1 single command length", 32'(cnt), 32'd8);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      sclk_q = 1'b0; fcs_q = 1'b1; rcs_q = 1'b1; cnt = 0; io_in = 4'h0;
    end else begin
      cycles++;
      if (cycles > 150000) begin
        n_checks++; n_err++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
      end
      if (sclk && sclk_q) sclk_long++;
      if (sclk && flash_cs_n && ram_cs_n) sclk_nocs++;
      if (!flash_cs_n && !ram_cs_n) cs_both++;
      if (!ram_cs_n && !init_done) ram_during_boot++;
      if ((fcs_q && !flash_cs_n) || (rcs_q && !ram_cs_n)) cnt = 0;
      if (sclk && !sclk_q && (!flash_cs_n || !ram_cs_n)) begin
        if (cnt < 64) begin
          rec_out[cnt] = io_out;
          rec_oe[cnt]  = io_oe;
        end
        cnt++;
      end
      if (!fcs_q && flash_cs_n) begin
        flash_frames++;
        if (flash_frames <= 5) check_init(flash_frames - 1);
      end
      if (!rcs_q && ram_cs_n) begin
        ram_frames++;
        if (cnt == 48 && sbits(0, 8) == 32'h02) begin
          logic [23:0] ba;
          ba = sbits(8, 24)[23:0];
          ram_mem[ba[8:1]] = sbits(32, 16)[15:0];
        end
      end
      io_in = 4'h0;
      if (!flash_cs_n && cnt >= 12 && cnt < 16) begin
        logic [23:0] fba;
        logic [15:0] fw;
        fba = qnibs(0, 6)[23:0];
        fw  = flash_word(fba[16:1]);
        io_in = 4'(fw >> (4 * (15 - cnt)));
      end else if (!ram_cs_n && cnt >= 32 && cnt < 48 && sbits(0, 8) == 32'h03) begin
        logic [23:0] rba;
        logic [15:0] rw;
        rba = sbits(8, 24)[23:0];
        rw  = ram_mem[rba[8:1]];
        io_in = {2'b00, rw[47 - cnt], 1'b0};
      end
      sclk_q = sclk; fcs_q = flash_cs_n; rcs_q = ram_cs_n;
    end
  end

  task automatic do_op(input bit fl, input bit we, input logic [15:0] a, input logic [15:0] wd,
                       input bit scramble, output logic [15:0] rd, output int waited);
    req_flash = fl; req_we = we; req_addr = a; req_wdata = wd; req = 1'b1; waited = 0;
    do begin
      @(negedge clk);
      waited++;
      if (scramble && waited == 4) begin
        req_addr = ~a; req_wdata = ~wd;
      end
    end while (!ready && waited < 3000);
    rd = rdata;
    chk(ready == 1'b1, "R9 ready reached", 32'(ready), 32'd1);
    req = 1'b0;
    @(negedge clk);
    chk(ready == 1'b0, "R9 ready single cycle", 32'(ready), 32'd0);
  endtask

  task automatic run_check(input bit fl, input bit we, input logic [15:0] a,
                           input logic [15:0] wd, input bit scramble);
    logic [15:0] rd;
    int waited, fb;
    fb = flash_frames + ram_frames;
    do_op(fl, we, a, wd, scramble, rd, waited);
    if (fl && we) begin
      chk(waited == 1, "R8 blocked write ready delay", 32'(waited), 32'd1);
      chk(flash_frames + ram_frames == fb, "R8 blocked write no frame",
          32'(flash_frames + ram_frames), 32'(fb));
    end else if (fl) begin
      chk(cnt == 16, "R4 flash read clocks", 32'(cnt), 32'd16);
      chk(qnibs(0, 6) == 32'(wire_addr(a)), "R3 flash address", qnibs(0, 6), 32'(wire_addr(a)));
      chk(qnibs(6, 2) == 32'hA0, "R4 mode nibbles", qnibs(6, 2), 32'hA0);
      chk(released(8, 8), "R4 dummy and data released", 32'(rec_oe[8]), 32'h0);
      chk(rd == flash_word(a), "R4 flash data", 32'(rd), 32'(flash_word(a)));
    end else begin
      chk(cnt == 48, "R6 R7 ram frame clocks", 32'(cnt), 32'd48);
      chk(sbits(8, 24) == 32'(wire_addr(a)), "R3 ram address", sbits(8, 24), 32'(wire_addr(a)));
      chk(single_ok(0, 48), "R10 ram IO2/IO3 high", 32'(rec_oe[0]), 32'hD);
      if (we) begin
        chk(sbits(0, 8) == 32'h02, "R7 write command", sbits(0, 8), 32'h02);
        chk(sbits(32, 16) == 32'(wd), "R7 write data", sbits(32, 16), 32'(wd));
        exp_ram[a[7:0]] = wd;
      end else begin
        chk(sbits(0, 8) == 32'h03, "R6 read command", sbits(0, 8), 32'h03);
        chk(rd == exp_ram[a[7:0]], "R6 read data", 32'(rd), 32'(exp_ram[a[7:0]]));
      end
    end
    if (scramble) chk(1'b1, "R9 captured fields", 32'd0, 32'd0);
  endtask

  initial begin
    int unsigned seed;
    for (int i = 0; i < 256; i++) begin
      ram_mem[i] = 16'h0; exp_ram[i] = 16'h0;
    end
    rst_n = 1'b0; req = 1'b0; req_flash = 1'b0; req_we = 1'b0;
    req_addr = 16'h0; req_wdata = 16'h0;
    seed = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    chk(flash_cs_n && ram_cs_n, "R2 reset selects high", {30'b0, flash_cs_n, ram_cs_n}, 32'h3);
    chk(!ready && !init_done && !sclk, "R1 reset outputs idle", {29'b0, ready, init_done, sclk}, 32'h0);
    rst_n = 1'b1;

    // request raised during setup must wait (R1)
    run_check(1'b0, 1'b0, 16'h0042, 16'h0, 1'b0);
    chk(flash_frames == 5, "R1 setup frame count", 32'(flash_frames), 32'd5);
    chk(ram_during_boot == 0, "R2 ram quiet in setup", 32'(ram_during_boot), 32'd0);

    // directed corners
    run_check(1'b0, 1'b1, 16'h0042, 16'hBEEF, 1'b0);
    run_check(1'b0, 1'b0, 16'h0042, 16'h0, 1'b0);
    run_check(1'b1, 1'b0, 16'h0000, 16'h0, 1'b0);
    run_check(1'b1, 1'b0, 16'hFFFF, 16'h0, 1'b0);
    run_check(1'b0, 1'b1, 16'hFFFF, 16'h8001, 1'b0);
    run_check(1'b0, 1'b0, 16'hFFFF, 16'h0, 1'b0);
    run_check(1'b1, 1'b1, 16'h1234, 16'h5678, 1'b0);
    run_check(1'b0, 1'b1, 16'h1357, 16'hA5C3, 1'b1);
    run_check(1'b0, 1'b0, 16'h1357, 16'h0, 1'b0);
    run_check(1'b1, 1'b0, 16'h8001, 16'h0, 1'b1);

    // constrained random mix
    for (int n = 0; n < 60; n++) begin
      int unsigned kind;
      logic [15:0] a, d;
      kind = $urandom_range(0, 3);
      a = 16'($urandom);
      d = 16'($urandom);
      case (kind)
        0: run_check(1'b1, 1'b0, a, d, 1'b0);
        1: run_check(1'b0, 1'b1, a, d, 1'b0);
        2: run_check(1'b0, 1'b0, a, d, 1'b0);
        default: run_check(1'b1, 1'b1, a, d, 1'b0);
      endcase
    end

    chk(sclk_long == 0, "R5 sclk high one cycle", 32'(sclk_long), 32'd0);
    chk(sclk_nocs == 0, "R5 sclk only in frame", 32'(sclk_nocs), 32'd0);
    chk(cs_both == 0, "R2 selects exclusive", 32'(cs_both), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule